// File: doc/BRIEF.md
# Valid-Ready Memory Bus Monitor

This block watches, without driving anything, a memory bus that carries one transfer at a time between a processor core and a memory. A transfer starts when the requester raises valid. It ends on the first rising clock edge where ready is also high. While valid is up, the requester presents an address, write data, a byte strobe and a flag that marks instruction fetches. The monitor checks the handshake and the request fields. It counts completed reads, writes and fetches, and it latches the first protocol violation it sees.

Two state machines do the work. The transfer tracker has two states. `TRK_IDLE` is the state with no transfer open. `TRK_WAIT` is the state where valid was seen without ready. The tracker takes the transition `TRK_IDLE -> TRK_WAIT` on valid without ready. It takes `TRK_WAIT -> TRK_IDLE` when ready arrives or when valid falls. It stays in `TRK_IDLE` on a zero-wait transfer. On entry to `TRK_WAIT` it captures the request fields.

The error recorder also has two states, `ERS_CLEAN` and `ERS_LATCHED`. It takes `ERS_CLEAN -> ERS_LATCHED` on the first violation and stores a code and an address at that point. Only reset returns it to `ERS_CLEAN`. The read-data bus has no effect on any check, so the monitor does not tap it.

Top module: `membus_monitor`

## Requirements
- R1: In the cycle after a synchronous active-low reset, err_flag is 0, err_code is 0, err_addr is 0 and all three counters are 0.
- R2: If valid falls while a transfer is still waiting for ready, the monitor latches code 1. The recorded address is the one captured when the transfer opened.
- R3: While a transfer waits, a change in the address, write data, strobe or fetch flag against the values captured at its start latches code 2. The recorded address is the captured address.
- R4: A strobe is legal only if it is 0000, 1111, 1100, 0011, 1000, 0100, 0010 or 0001 (bit i enables byte i). Any other strobe seen while valid is high latches code 3.
- R5: A fetch (fetch flag high) with a nonzero strobe latches code 4.
- R6: A two-byte strobe needs address bit 0 to be 0. The full-word strobe needs address bits 1:0 to be 00. Violating either latches code 5. A single-byte write and a read may use any address.
- R7: Ready high in the same cycle that valid rises is not an error, and neither is ready held high across back-to-back transfers. A transfer with wait states that keeps its fields stable is not an error either.
- R8: Each edge with valid and ready high increments exactly one counter. cnt_fetch counts when the fetch flag is set. Otherwise cnt_write counts when the strobe is nonzero and cnt_read counts when it is zero. Counting happens whether or not the transfer is in error.
- R9: Ready without valid changes no counter and raises no error.
- R10: The error flag is sticky. Once set, the code and address of the first violation hold through later violations until reset.
- R11: For codes 3, 4 and 5, err_addr is the address on the bus in the offending cycle.
- R12: When several violations occur in the same cycle, the lowest code is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Requester valid |
| bus_ready | input | 1 | Responder ready |
| bus_fetch | input | 1 | Transfer is an instruction fetch |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte write enables, zero for a read |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of first violation |
| err_addr | output | 32 | Address of first violating transfer |
| cnt_read | output | 16 | Completed data reads |
| cnt_write | output | 16 | Completed writes |
| cnt_fetch | output | 16 | Completed fetches |

## Verification
The assertions take for granted that the bus inputs are known values whenever reset is released. They also assume reset is held for at least one edge before the bus runs, so the tracker starts in `TRK_IDLE` with nothing captured. The stimulus changes every input only on the falling clock edge and starts each table vector from a fresh reset. It breaks the rules only through single, deliberate violations whose expected code, address and counter values the bench works out from the requirements.

// File: rtl/membus_mon_pkg.sv
package membus_mon_pkg;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_DROP    = 3'd1,
        ERR_FIELD   = 3'd2,
        ERR_STRB    = 3'd3,
        ERR_FETCHWR = 3'd4,
        ERR_ALIGN   = 3'd5
    } err_code_e;

    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_WAIT = 1'b1
    } trk_state_e;

    typedef enum logic {
        ERS_CLEAN   = 1'b0,
        ERS_LATCHED = 1'b1
    } ers_state_e;

    localparam int KIND_READ  = 0;
    localparam int KIND_WRITE = 1;
    localparam int KIND_FETCH = 2;
    localparam int NUM_KINDS  = 3;

endpackage

// File: rtl/mbm_strobe_check.sv
module mbm_strobe_check #(
    parameter int SW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   valid,
    input  logic [SW-1:0]          strb,
    input  logic [$clog2(SW)-1:0]  addr_lo,
    output logic                   legal,
    output logic                   misaligned
);
    localparam int LW     = $clog2(SW);
    localparam int LEVELS = LW + 1;

    always_comb begin
        legal      = (strb == '0);
        misaligned = 1'b0;
        for (int k = 0; k < LEVELS; k++) begin
            for (int i = 0; i < SW; i += (1 << k)) begin
                if (strb == SW'(((1 << (1 << k)) - 1) << i)) begin
                    legal = 1'b1;
                    if ((addr_lo & LW'((1 << k) - 1)) != '0) misaligned = 1'b1;
                end
            end
        end
    end

    AST_LEGAL_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && legal) |-> ($countones(strb) inside {0, 1, 2, 4})); // R4
    AST_SINGLE_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $countones(strb) == 1) |-> !misaligned); // R6

endmodule

// File: rtl/mbm_tracker.sv
module mbm_tracker
    import membus_mon_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          ready,
    input  logic          fetch,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] strb,
    output logic          drop_err,
    output logic          field_err,
    output logic [AW-1:0] hold_addr
);
    localparam int FW = 1 + SW + DW + AW;

    trk_state_e    state_q, state_d;
    logic [FW-1:0] held_q;
    logic [FW-1:0] cur;

    assign cur = {fetch, strb, wdata, addr};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TRK_IDLE && valid && !ready) held_q <= cur;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: if (valid && !ready) state_d = TRK_WAIT;
            TRK_WAIT: if (!valid || ready) state_d = TRK_IDLE;
        endcase
    end

    always_comb begin
        drop_err  = (state_q == TRK_WAIT) && !valid;
        field_err = (state_q == TRK_WAIT) && valid && (cur != held_q);
        hold_addr = held_q[AW-1:0];
    end

    AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> (state_q == TRK_IDLE)); // R7
    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_WAIT && valid && !ready) |=> $stable(held_q)); // R3

endmodule

// File: rtl/mbm_counter.sv
module mbm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + W'(1);
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count)); // R9
endmodule

// File: rtl/membus_monitor.sv
module membus_monitor
    import membus_mon_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int SW    = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_ready,
    input  logic             bus_fetch,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [SW-1:0]    bus_wstrb,
    output logic             err_flag,
    output logic [2:0]       err_code,
    output logic [AW-1:0]    err_addr,
    output logic [CNT_W-1:0] cnt_read,
    output logic [CNT_W-1:0] cnt_write,
    output logic [CNT_W-1:0] cnt_fetch
);
    localparam int LW = $clog2(SW);

    logic          drop_err, field_err, strb_legal, misaligned;
    logic [AW-1:0] hold_addr;

    mbm_tracker #(.AW(AW), .DW(DW), .SW(SW)) u_trk (
        .clk(clk), .rst_n(rst_n), .valid(bus_valid), .ready(bus_ready),
        .fetch(bus_fetch), .addr(bus_addr), .wdata(bus_wdata), .strb(bus_wstrb),
        .drop_err(drop_err), .field_err(field_err), .hold_addr(hold_addr)
    );

    mbm_strobe_check #(.SW(SW)) u_strb (
        .clk(clk), .rst_n(rst_n), .valid(bus_valid), .strb(bus_wstrb),
        .addr_lo(bus_addr[LW-1:0]), .legal(strb_legal), .misaligned(misaligned)
    );

    // completion classification
    logic                 done;
    logic [NUM_KINDS-1:0] inc;
    logic [CNT_W-1:0]     cnt [NUM_KINDS];

    assign done             = bus_valid && bus_ready;
    assign inc[KIND_FETCH]  = done && bus_fetch;
    assign inc[KIND_WRITE]  = done && !bus_fetch && (bus_wstrb != '0);
    assign inc[KIND_READ]   = done && !bus_fetch && (bus_wstrb == '0);

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_cnt
        mbm_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(inc[k]), .count(cnt[k])
        );
    end

    assign cnt_read  = cnt[KIND_READ];
    assign cnt_write = cnt[KIND_WRITE];
    assign cnt_fetch = cnt[KIND_FETCH];

    // violation selection, lowest code wins
    err_code_e     hit_code;
    logic [AW-1:0] hit_addr;

    always_comb begin
        hit_code = ERR_NONE;
        hit_addr = bus_addr;
        if (drop_err) begin
            hit_code = ERR_DROP;
            hit_addr = hold_addr;
        end else if (field_err) begin
            hit_code = ERR_FIELD;
            hit_addr = hold_addr;
        end else if (bus_valid && !strb_legal) begin
            hit_code = ERR_STRB;
        end else if (bus_valid && bus_fetch && (bus_wstrb != '0)) begin
            hit_code = ERR_FETCHWR;
        end else if (bus_valid && misaligned) begin
            hit_code = ERR_ALIGN;
        end
    end

    // sticky error recorder
    ers_state_e    ers_q, ers_d;
    err_code_e     code_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ers_q  <= ERS_CLEAN;
            code_q <= ERR_NONE;
            addr_q <= '0;
        end else begin
            ers_q <= ers_d;
            if (ers_q == ERS_CLEAN && hit_code != ERR_NONE) begin
                code_q <= hit_code;
                addr_q <= hit_addr;
            end
        end
    end

    always_comb begin
        ers_d = ers_q;
        unique case (ers_q)
            ERS_CLEAN:   if (hit_code != ERR_NONE) ers_d = ERS_LATCHED;
            ERS_LATCHED: ers_d = ERS_LATCHED;
        endcase
    end

    always_comb begin
        err_flag = (ers_q == ERS_LATCHED);
        err_code = code_q;
        err_addr = addr_q;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R10
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> ($stable(err_code) && $stable(err_addr))); // R10
    AST_FLAG_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (err_code != 3'd0)); // R10
    AST_READ_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bus_fetch && bus_wstrb == '0) |=> (cnt_read == $past(cnt_read) + CNT_W'(1))); // R8
    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inc)); // R8
    AST_DROP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && drop_err) |=> (err_code == 3'd1)); // R2

endmodule

// File: tb/membus_monitor_test.sv
module membus_monitor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_ready = 1'b0, bus_fetch = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic        err_flag;
    logic [2:0]  err_code;
    logic [31:0] err_addr;
    logic [15:0] cnt_read, cnt_write, cnt_fetch;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    membus_monitor uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_fetch(bus_fetch), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wstrb(bus_wstrb), .err_flag(err_flag), .err_code(err_code),
        .err_addr(err_addr), .cnt_read(cnt_read), .cnt_write(cnt_write),
        .cnt_fetch(cnt_fetch)
    );

    // {fetch, strobe[3:0], addr[1:0], expected code[2:0]}
    localparam int NV = 14;
    localparam logic [9:0] VEC [NV] = '{
        {1'b0, 4'b0000, 2'b00, 3'd0},
        {1'b0, 4'b0000, 2'b11, 3'd0},
        {1'b0, 4'b1111, 2'b00, 3'd0},
        {1'b0, 4'b1111, 2'b10, 3'd5},
        {1'b0, 4'b0011, 2'b10, 3'd0},
        {1'b0, 4'b1100, 2'b01, 3'd5},
        {1'b0, 4'b0001, 2'b11, 3'd0},
        {1'b0, 4'b1000, 2'b01, 3'd0},
        {1'b0, 4'b0101, 2'b00, 3'd3},
        {1'b0, 4'b1110, 2'b00, 3'd3},
        {1'b1, 4'b0000, 2'b00, 3'd0},
        {1'b1, 4'b1111, 2'b00, 3'd4},
        {1'b1, 4'b0110, 2'b01, 3'd3},
        {1'b0, 4'b0011, 2'b01, 3'd5}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(logic v, logic r, logic f, logic [31:0] a,
                         logic [31:0] d, logic [3:0] s);
        bus_valid = v; bus_ready = r; bus_fetch = f;
        bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 flag", 32'(err_flag), 0);
        chk("R1 code", 32'(err_code), 0);
        chk("R1 addr", err_addr, 0);
        chk("R1 counters", 32'(cnt_read) + 32'(cnt_write) + 32'(cnt_fetch), 0);

        // table walk: one zero-wait transfer per vector (R4 R5 R6 R8 R11 R12)
        for (int i = 0; i < NV; i++) begin
            logic        f;
            logic [3:0]  s;
            logic [31:0] a;
            logic [2:0]  c;
            f = VEC[i][9]; s = VEC[i][8:5]; c = VEC[i][2:0];
            a = 32'h0000_4000 | (32'(i) << 4) | 32'(VEC[i][4:3]);
            do_reset();
            drive(1, 1, f, a, 32'hA5A5_0000 + 32'(i), s);
            drive(0, 0, 0, 0, 0, 0);
            chk($sformatf("R4/R5/R6/R12 code vec%0d", i), 32'(err_code), 32'(c));
            chk($sformatf("R11 addr vec%0d", i), err_addr, (c != 0) ? a : 32'h0);
            chk($sformatf("R8 fetch vec%0d", i), 32'(cnt_fetch), f ? 1 : 0);
            chk($sformatf("R8 write vec%0d", i), 32'(cnt_write), (!f && s != 0) ? 1 : 0);
            chk($sformatf("R8 read vec%0d", i), 32'(cnt_read), (!f && s == 0) ? 1 : 0);
        end

        // R2 valid dropped before ready
        do_reset();
        drive(1, 0, 0, 32'h0000_1230, 0, 4'b0000);
        drive(0, 0, 0, 32'h0000_9990, 0, 4'b0000);
        chk("R2 code", 32'(err_code), 1);
        chk("R2 addr", err_addr, 32'h0000_1230);
        chk("R2 no count", 32'(cnt_read), 0);

        // R3 write data changes during wait, address moves later too
        do_reset();
        drive(1, 0, 0, 32'h0000_2000, 32'h1111_1111, 4'b1111);
        drive(1, 0, 0, 32'h0000_2000, 32'h2222_2222, 4'b1111);
        chk("R3 code", 32'(err_code), 2);
        chk("R3 addr", err_addr, 32'h0000_2000);
        drive(1, 1, 0, 32'h0000_2004, 32'h2222_2222, 4'b1111);
        drive(0, 0, 0, 0, 0, 0);
        chk("R10 code after second fault", 32'(err_code), 2);
        chk("R3 write counted", 32'(cnt_write), 1);

        // R7 wait states with stable fields, then ready held high back to back
        do_reset();
        drive(1, 0, 1, 32'h0000_0100, 0, 4'b0000);
        drive(1, 0, 1, 32'h0000_0100, 0, 4'b0000);
        drive(1, 1, 1, 32'h0000_0100, 0, 4'b0000);
        drive(1, 1, 0, 32'h0000_0200, 0, 4'b0000);
        drive(1, 1, 0, 32'h0000_0204, 32'h77, 4'b0001);
        drive(0, 1, 0, 0, 0, 0);
        chk("R7 no error", 32'(err_flag), 0);
        chk("R7 fetches", 32'(cnt_fetch), 1);
        chk("R7 reads", 32'(cnt_read), 1);
        chk("R7 writes", 32'(cnt_write), 1);

        // R9 ready alone
        drive(0, 1, 0, 32'h0000_0300, 0, 4'b0101);
        drive(0, 1, 1, 32'h0000_0301, 0, 4'b1111);
        drive(0, 0, 0, 0, 0, 0);
        chk("R9 no error", 32'(err_flag), 0);
        chk("R9 counters", 32'(cnt_read) + 32'(cnt_write) + 32'(cnt_fetch), 3);

        // R10 sticky first error, then reset clears
        do_reset();
        drive(1, 1, 0, 32'h0000_0500, 0, 4'b1001);
        drive(1, 1, 1, 32'h0000_0600, 0, 4'b1111);
        drive(0, 0, 0, 0, 0, 0);
        chk("R10 code held", 32'(err_code), 3);
        chk("R10 addr held", err_addr, 32'h0000_0500);
        do_reset();
        chk("R10 reset clears flag", 32'(err_flag), 0);
        chk("R10 reset clears code", 32'(err_code), 0);

        finish_run();
    end

endmodule